// File: doc/BRIEF.md
# Dual GPIO Port with Converter Channel Claim

This block holds two general-purpose I/O ports that share their pins with the inputs of an analog-to-digital converter: an 8-bit port B and a 7-bit port D, fifteen pins in all. Each pin has its own output data latch and direction bit. Software reaches them through a small register window on a simple write-strobe bus, and reads are combinational from the address.

A 5-bit channel code from the converter's control logic may claim one pin. The claimed pin's driver is switched off, whatever its direction bit holds. The pin then leaves port control and its synchronized level is passed to the converter front end. Software can still write the latch and direction registers of a claimed pin, and these writes are stored. They take effect only after the claim moves to another pin. A read of a claimed pin never shows the pin level.

Top module: `gpio_adc_share`

## Requirements
- R1: After reset, every data latch and direction bit is 0, so every pin is an input: `pinOutEn` and `pinOut` are all 0, and both direction registers read back as 0.
- R2: The register window is decoded from `busAddr`: 0 is port B data, 1 is port D data, 2 is port B direction and 3 is port D direction. A write with `busWe` high is stored at the rising clock edge. Bit 7 of the port D data and direction registers always reads 0 and ignores writes.
- R3: An unclaimed pin whose direction bit is 1 drives its latch value, with `pinOutEn` high. A data read of that pin returns the latch value.
- R4: A data read of an unclaimed pin whose direction bit is 0 returns the pin level after a two-flop synchronizer. A change at `pinIn` is visible after two rising edges.
- R5: Channel codes 0 to 14 map to pins. Code c claims port B bit c when c < 8, and port D bit c-8 otherwise. Flattened pin index c is bit c of `pinIn`, `pinOut` and `pinOutEn`. The claimed pin has `pinOutEn` = 0 and `pinOut` = 0.
- R6: A data read of a claimed pin returns 0 when its direction bit is 0, and its latch value when its direction bit is 1.
- R7: Writes to the latch and direction bits of a claimed pin are stored. When the claim is released, the pin drives according to the stored values.
- R8: Channel codes 15 to 31 claim no pin. `claimValid` is then 0 and every pin acts as ordinary GPIO.
- R9: While a pin is claimed, `claimValid` is 1, `claimIdx` equals the channel code and `adcLevel` is that pin's synchronized level. Otherwise `claimIdx` and `adcLevel` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 2 | Register select |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Combinational read data for `busAddr` |
| chanSel | input | 5 | Converter channel code |
| pinIn | input | 15 | Pin levels; bits 7..0 are port B, bits 14..8 are port D |
| pinOut | output | 15 | Output data to the pin drivers |
| pinOutEn | output | 15 | Driver enables, 1 drives the pin |
| claimValid | output | 1 | A pin is claimed by the converter |
| claimIdx | output | 4 | Flattened index of the claimed pin |
| adcLevel | output | 1 | Synchronized level of the claimed pin |

## Verification
The assertions take `chanSel`, `busAddr` and `busWe` to be stable and known around each rising edge. The bench drives all inputs at the falling edge, so this holds. `pinIn` is the only input treated as asynchronous, and it is sampled only through the synchronizer. Random stimulus covers all 32 channel codes, so claims go both to real pins and to unused codes. Checks are made three edges after each change, which gives the synchronizer time to settle.

// File: rtl/gpio_adc_share_pkg.sv
package gpio_adc_share_pkg;

  typedef enum logic [1:0] {
    REG_DATA_B = 2'd0,
    REG_DATA_D = 2'd1,
    REG_DIR_B  = 2'd2,
    REG_DIR_D  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    wrDataB;
    logic    wrDataD;
    logic    wrDirB;
    logic    wrDirD;
    regSel_e rdSel;
  } portStrobe_t;

endpackage

// File: rtl/gpio_adc_share_ctrl.sv
module gpio_adc_share_ctrl
  import gpio_adc_share_pkg::*;
#(
  parameter int PORT_B_W = 8,
  parameter int PORT_D_W = 7,
  parameter int SEL_W    = 5,
  localparam int NUM_PINS = PORT_B_W + PORT_D_W,
  localparam int IDX_W    = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWe,
  input  logic [1:0]          busAddr,
  input  logic [SEL_W-1:0]    chanSel,
  output portStrobe_t         strobe,
  output logic [NUM_PINS-1:0] claimMask,
  output logic                claimValid,
  output logic [IDX_W-1:0]    claimIdx
);

  regSel_e addrSel;
  logic    claimHit;

  assign addrSel = regSel_e'(busAddr);

  always_comb begin
    strobe         = '0;
    strobe.rdSel   = addrSel;
    strobe.wrDataB = busWe && (addrSel == REG_DATA_B);
    strobe.wrDataD = busWe && (addrSel == REG_DATA_D);
    strobe.wrDirB  = busWe && (addrSel == REG_DIR_B);
    strobe.wrDirD  = busWe && (addrSel == REG_DIR_D);
  end

  assign claimHit = (chanSel < SEL_W'(NUM_PINS));

  for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_claim
    assign claimMask[gi] = claimHit && (chanSel == SEL_W'(gi));
  end

  assign claimValid = |claimMask;
  assign claimIdx   = claimHit ? chanSel[IDX_W-1:0] : '0;

  // R8: a code past the last pin never raises a claim
  a_r8_no_claim_high: assert property (@(posedge clk) disable iff (!rstN)
    (chanSel >= SEL_W'(NUM_PINS)) |-> (!claimValid && claimMask == '0));

  // R2: at most one write strobe per cycle
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrDataB, strobe.wrDataD, strobe.wrDirB, strobe.wrDirD}));

endmodule

// File: rtl/gpio_adc_share_dp.sv
module gpio_adc_share_dp
  import gpio_adc_share_pkg::*;
#(
  parameter int PORT_B_W    = 8,
  parameter int PORT_D_W    = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_PINS = PORT_B_W + PORT_D_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  portStrobe_t         strobe,
  input  logic [DATA_W-1:0]   busWrData,
  output logic [DATA_W-1:0]   busRdData,
  input  logic [NUM_PINS-1:0] claimMask,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOutEn,
  output logic                adcLevel
);

  logic [PORT_B_W-1:0] latB, dirB;
  logic [PORT_D_W-1:0] latD, dirD;
  logic [NUM_PINS-1:0] latAll, dirAll;
  logic [NUM_PINS-1:0] syncQ [SYNC_STAGES];
  logic [NUM_PINS-1:0] pinLevel;
  logic [NUM_PINS-1:0] readBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latB <= '0;
      latD <= '0;
      dirB <= '0;
      dirD <= '0;
    end else begin
      if (strobe.wrDataB) latB <= busWrData[PORT_B_W-1:0];
      if (strobe.wrDataD) latD <= busWrData[PORT_D_W-1:0];
      if (strobe.wrDirB)  dirB <= busWrData[PORT_B_W-1:0];
      if (strobe.wrDirD)  dirD <= busWrData[PORT_D_W-1:0];
    end
  end

  for (genvar gs = 0; gs < SYNC_STAGES; gs++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[gs] <= '0;
      else if (gs == 0) syncQ[gs] <= pinIn;
      else syncQ[gs] <= syncQ[(gs == 0) ? 0 : gs-1];
    end
  end

  assign pinLevel = syncQ[SYNC_STAGES-1];
  assign latAll   = {latD, latB};
  assign dirAll   = {dirD, dirB};

  for (genvar gp = 0; gp < NUM_PINS; gp++) begin : g_pin
    assign pinOutEn[gp] = dirAll[gp] & ~claimMask[gp];
    assign pinOut[gp]   = latAll[gp] & ~claimMask[gp];
    assign readBit[gp]  = dirAll[gp] ? latAll[gp]
                                     : (claimMask[gp] ? 1'b0 : pinLevel[gp]);
  end

  assign adcLevel = |(pinLevel & claimMask);

  always_comb begin
    unique case (strobe.rdSel)
      REG_DATA_B: busRdData = DATA_W'(readBit[PORT_B_W-1:0]);
      REG_DATA_D: busRdData = DATA_W'(readBit[NUM_PINS-1:PORT_B_W]);
      REG_DIR_B:  busRdData = DATA_W'(dirB);
      default:    busRdData = DATA_W'(dirD);
    endcase
  end

  // R7: latch only changes on its own write strobe, claimed or not
  a_r7_latch_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrDataB |=> $stable(latB));

  a_r7_dir_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrDirD |=> $stable(dirD));

endmodule

// File: rtl/gpio_adc_share.sv
module gpio_adc_share
  import gpio_adc_share_pkg::*;
#(
  parameter int PORT_B_W    = 8,
  parameter int PORT_D_W    = 7,
  parameter int DATA_W      = 8,
  parameter int SEL_W       = 5,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_PINS = PORT_B_W + PORT_D_W,
  localparam int IDX_W    = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWe,
  input  logic [1:0]          busAddr,
  input  logic [DATA_W-1:0]   busWrData,
  output logic [DATA_W-1:0]   busRdData,
  input  logic [SEL_W-1:0]    chanSel,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOutEn,
  output logic                claimValid,
  output logic [IDX_W-1:0]    claimIdx,
  output logic                adcLevel
);

  portStrobe_t         strobe;
  logic [NUM_PINS-1:0] claimMask;

  gpio_adc_share_ctrl #(
    .PORT_B_W(PORT_B_W), .PORT_D_W(PORT_D_W), .SEL_W(SEL_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .chanSel(chanSel), .strobe(strobe), .claimMask(claimMask),
    .claimValid(claimValid), .claimIdx(claimIdx)
  );

  gpio_adc_share_dp #(
    .PORT_B_W(PORT_B_W), .PORT_D_W(PORT_D_W), .DATA_W(DATA_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWrData(busWrData),
    .busRdData(busRdData), .claimMask(claimMask), .pinIn(pinIn),
    .pinOut(pinOut), .pinOutEn(pinOutEn), .adcLevel(adcLevel)
  );

  // R5: the claimed pin is never driven
  a_r5_claim_hiz: assert property (@(posedge clk) disable iff (!rstN)
    claimValid |-> (!pinOutEn[claimIdx] && !pinOut[claimIdx]));

  // R9: the reported index follows the channel code
  a_r9_idx_match: assert property (@(posedge clk) disable iff (!rstN)
    claimValid |-> (SEL_W'(claimIdx) == chanSel));

  // R2: unused top bits of the port D window read as 0
  a_r2_dpad: assert property (@(posedge clk) disable iff (!rstN)
    busAddr[0] |-> (busRdData[DATA_W-1:PORT_D_W] == '0));

endmodule

// File: tb/gpio_adc_share_tb.sv
module gpio_adc_share_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [7:0]  busWrData = 8'd0;
  logic [7:0]  busRdData;
  logic [4:0]  chanSel = 5'd31;
  logic [14:0] pinIn = 15'd0;
  logic [14:0] pinOut, pinOutEn;
  logic        claimValid;
  logic [3:0]  claimIdx;
  logic        adcLevel;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  logic [14:0] mLat = '0;
  logic [14:0] mDir = '0;

  always #5 clk = ~clk;

  gpio_adc_share u_dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .chanSel(chanSel),
    .pinIn(pinIn), .pinOut(pinOut), .pinOutEn(pinOutEn),
    .claimValid(claimValid), .claimIdx(claimIdx), .adcLevel(adcLevel)
  );

  function automatic logic [14:0] expClaim();
    logic [14:0] m = '0;
    if (chanSel < 5'd15) m[chanSel[3:0]] = 1'b1;
    return m;
  endfunction

  function automatic logic [7:0] expRead(input logic [1:0] a);
    logic [14:0] c = expClaim();
    logic [14:0] bits;
    for (int i = 0; i < 15; i++)
      bits[i] = mDir[i] ? mLat[i] : (c[i] ? 1'b0 : pinIn[i]);
    case (a)
      2'd0: return bits[7:0];
      2'd1: return {1'b0, bits[14:8]};
      2'd2: return mDir[7:0];
      default: return {1'b0, mDir[14:8]};
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWe = 1'b0;
    if (a[1]) begin
      if (a[0]) mDir[14:8] = d[6:0]; else mDir[7:0] = d;
    end else begin
      if (a[0]) mLat[14:8] = d[6:0]; else mLat[7:0] = d;
    end
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkAll(input string ctx);
    logic [14:0] c = expClaim();
    for (int a = 0; a < 4; a++) begin
      busAddr = 2'(a);
      #1;
      check({ctx, " R2 R3 R4 R6 read"}, 32'(busRdData), 32'(expRead(2'(a))));
    end
    check({ctx, " R3 R5 R7 oe"}, 32'(pinOutEn), 32'(mDir & ~c));
    check({ctx, " R3 R5 R7 out"}, 32'(pinOut), 32'(mLat & ~c));
    check({ctx, " R8 R9 valid"}, 32'(claimValid), 32'(c != 0));
    check({ctx, " R9 idx"}, 32'(claimIdx), (c != 0) ? 32'(chanSel) : 32'd0);
    check({ctx, " R9 level"}, 32'(adcLevel), 32'(|(c & pinIn)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nErrors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 oe", 32'(pinOutEn), 32'd0);
    check("R1 out", 32'(pinOut), 32'd0);
    busAddr = 2'd2; #1; check("R1 dirB", 32'(busRdData), 32'd0);
    busAddr = 2'd3; #1; check("R1 dirD", 32'(busRdData), 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    settle();
    checkAll("R1 post");

    // R2 port D bit 7 ignored
    regWrite(2'd1, 8'hFF);
    regWrite(2'd3, 8'hFF);
    settle();
    checkAll("R2 dpad");

    // R3 output on port B, R4 input sampling
    regWrite(2'd2, 8'h0F);
    regWrite(2'd0, 8'hA5);
    pinIn = 15'h5A3C;
    settle();
    checkAll("R3 R4 mix");

    // R6 claimed pin with dir 0 and dir 1
    chanSel = 5'd5;
    settle();
    checkAll("R6 dir0");
    chanSel = 5'd2;
    settle();
    checkAll("R6 dir1");

    // R7 writes while claimed, then release
    regWrite(2'd0, 8'h04);
    regWrite(2'd2, 8'h04);
    settle();
    checkAll("R7 held");
    chanSel = 5'd20;
    settle();
    checkAll("R7 released");

    // R8 boundary codes
    chanSel = 5'd14; settle(); checkAll("R5 top pin");
    chanSel = 5'd15; settle(); checkAll("R8 code15");
    chanSel = 5'd31; settle(); checkAll("R8 code31");
    chanSel = 5'd8;  settle(); checkAll("R5 first D");

    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(3, 0);
      if (op == 0) regWrite(2'($urandom_range(3, 0)), 8'($urandom()));
      else if (op == 1) begin
        @(negedge clk); chanSel = 5'($urandom_range(31, 0));
      end else begin
        @(negedge clk); pinIn = 15'($urandom());
      end
      settle();
      checkAll("rand");
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

endmodule